// File: doc/BRIEF.md
# Pipelined Cache Write Path

This block is the store side of a small direct-mapped cache. Each write has its tag compared in the cycle it is accepted. A write that hits does not go into the data array in that cycle. It waits in a one-entry delayed buffer, and it is written into the array during a later cycle, normally the cycle that accepts the next write. Back-to-back hit writes therefore stream at one per cycle. The single-ported data array never has to serve a tag check and a data update in the same cycle.

Reads look up the tag and the delayed buffer together. A read of the exact word that sits in the buffer is answered from the buffer with no stall. Any other read needs the array. While a buffered write is pending, that read is held for one cycle so the buffered write can retire first. Misses of either kind are reported on a miss port to the next level. Before a miss is reported, the buffer is always drained. The next level installs lines through a fill port. The fill waits one cycle if a buffered write still has to retire.

The CPU request port is valid/ready. A request is taken in any cycle where `req_valid` and `req_ready` are both high. The requester must hold the request stable while `req_ready` is low. The read response and the miss report have no back-pressure. They are single-cycle pulses in the acceptance cycle, and the consumer must take them. The fill port is valid/ready in the same way.

Top module: `cwp_write_path`

## Requirements
- R1: After reset every line is invalid and the delayed buffer is empty. `req_ready` and `fill_ready` are high, and the first read of any address reports a miss.
- R2: A write that hits is accepted in the cycle it is presented. Consecutive hit writes are each accepted with no idle cycle between them. A later read of a written word returns the newest value, including when one word is written twice in a row.
- R3: A read hit of the same word as the buffered write is accepted with no stall. It returns the buffered data in its acceptance cycle.
- R4: A read hit of any other word while a write is buffered sees `req_ready` low for exactly one cycle. It is then accepted and answered from the array, which by then holds the buffered write.
- R5: A write that misses is not buffered and does not change the cached data. A later read of the resident line at that index still returns its earlier contents.
- R6: A request that will miss while a write is buffered sees `req_ready` low for exactly one cycle, during which the buffer drains. The miss is then reported with the buffer empty.
- R7: A read that misses is accepted, and `miss_valid` pulses in its acceptance cycle with `miss_write` low and `miss_addr` equal to the request address. No response is given.
- R8: A fill is taken when `fill_valid` and `fill_ready` are both high. It marks line `fill_addr` valid and loads word w of the line from `fill_data[w*DW +: DW]`. `fill_ready` is low only while a write is buffered, and that write retires in the same cycle. `req_ready` is low in every cycle that `fill_valid` is high.
- R9: Request addresses split as {tag, index, word}. The word offset is in the low OFF_W bits, the index is in the next IDX_W bits, and the tag is in the top TAG_W bits. `fill_addr` is {tag, index}. Two addresses with the same index and different tags evict each other.
- R10: `rsp_valid` is high only in the acceptance cycle of a read hit. It carries the addressed word. `rsp_valid` and `miss_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | TAG_W+IDX_W+OFF_W | Word address {tag, index, word} |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read hit answered this cycle |
| rsp_rdata | output | DW | Read data |
| miss_valid | output | 1 | Accepted request missed |
| miss_write | output | 1 | Missing request was a write |
| miss_addr | output | TAG_W+IDX_W+OFF_W | Address that missed |
| fill_valid | input | 1 | Line fill present |
| fill_ready | output | 1 | Fill taken this cycle if valid |
| fill_addr | input | TAG_W+IDX_W | Line address {tag, index} |
| fill_data | input | (2**OFF_W)*DW | Line contents, word 0 in low bits |

## Verification
The bench targets the moments when the delayed buffer and the array disagree:
- **Read of the buffered word.** A design that skipped the bypass would return the stale array word.
- **Read of a different word while a write is pending.** A design that read before retiring the write would hand back old data, or would never raise `req_ready` again.
- **Miss or fill behind a pending write.** A design that did not drain first would lose the buffered store when the fill overwrote the line, or would report the miss a cycle early.
- **Write miss.** A design that buffered it would corrupt the resident line of another tag.
- **Two writes to one word in a row.** A design that committed in the wrong order would leave the older value.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

  // Operation performed on the single data-array port in a cycle.
  typedef enum logic [1:0] {
    ARR_IDLE   = 2'd0,
    ARR_COMMIT = 2'd1,
    ARR_FILL   = 2'd2
  } arr_op_e;

endpackage

// File: rtl/cwp_tag_store.sv
module cwp_tag_store #(
  parameter int TAG_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             fl_en,
  input  logic [IDX_W-1:0] fl_idx,
  input  logic [TAG_W-1:0] fl_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] line_ok;
  logic [TAG_W-1:0] line_tag [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_ok <= '0;
      for (int l = 0; l < LINES; l++) line_tag[l] <= '0;
    end else if (fl_en) begin
      line_ok[fl_idx]  <= 1'b1;
      line_tag[fl_idx] <= fl_tag;
    end
  end

  assign lk_hit = line_ok[lk_idx] && (line_tag[lk_idx] == lk_tag);

endmodule

// File: rtl/cwp_data_store.sv
module cwp_data_store
  import cwp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IDX_W = 3,
  parameter int OFF_W = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  arr_op_e                 op,
  input  logic [IDX_W+OFF_W-1:0]  w_loc,
  input  logic [DW-1:0]           w_word,
  input  logic [(2**OFF_W)*DW-1:0] fill_line,
  input  logic [IDX_W+OFF_W-1:0]  r_loc,
  output logic [DW-1:0]           r_word
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  logic [IDX_W-1:0] w_idx;
  logic [OFF_W-1:0] w_off;
  logic [IDX_W-1:0] r_idx;
  logic [OFF_W-1:0] r_off;
  logic [DW-1:0]    col_rd [WORDS];

  assign {w_idx, w_off} = w_loc;
  assign {r_idx, r_off} = r_loc;

  // One column of storage per word position in a line.
  for (genvar w = 0; w < WORDS; w++) begin : g_col
    logic [DW-1:0] col [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int l = 0; l < LINES; l++) col[l] <= '0;
      end else if (op == ARR_FILL) begin
        col[w_idx] <= fill_line[w*DW +: DW];
      end else if (op == ARR_COMMIT && w_off == OFF_W'(w)) begin
        col[w_idx] <= w_word;
      end
    end

    assign col_rd[w] = col[r_idx];
  end

  assign r_word = col_rd[r_off];

endmodule

// File: rtl/cwp_delay_buf.sv
module cwp_delay_buf #(
  parameter int KEY_W = 4,
  parameter int LOC_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [KEY_W-1:0] ld_key,
  input  logic [LOC_W-1:0] ld_loc,
  input  logic [DW-1:0]    ld_data,
  input  logic [KEY_W-1:0] pr_key,
  input  logic [LOC_W-1:0] pr_loc,
  output logic             held,
  output logic [LOC_W-1:0] held_loc,
  output logic [DW-1:0]    held_data,
  output logic             pr_match
);
  logic [KEY_W-1:0] held_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_key  <= '0;
      held_loc  <= '0;
      held_data <= '0;
    end else if (load) begin
      held      <= 1'b1;
      held_key  <= ld_key;
      held_loc  <= ld_loc;
      held_data <= ld_data;
    end else if (clear) begin
      held <= 1'b0;
    end
  end

  assign pr_match = held && (held_key == pr_key) && (held_loc == pr_loc);

endmodule

// File: rtl/cwp_write_path.sv
module cwp_write_path
  import cwp_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int IDX_W = 3,
  parameter int OFF_W = 1,
  parameter int DW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [TAG_W+IDX_W+OFF_W-1:0] req_addr,
  input  logic [DW-1:0]                req_wdata,
  output logic                         rsp_valid,
  output logic [DW-1:0]                rsp_rdata,
  output logic                         miss_valid,
  output logic                         miss_write,
  output logic [TAG_W+IDX_W+OFF_W-1:0] miss_addr,
  input  logic                         fill_valid,
  output logic                         fill_ready,
  input  logic [TAG_W+IDX_W-1:0]       fill_addr,
  input  logic [(2**OFF_W)*DW-1:0]     fill_data
);
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
  localparam int LOC_W  = IDX_W + OFF_W;

  logic [TAG_W-1:0] req_tag;
  logic [LOC_W-1:0] req_loc;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] fl_tag;
  logic [IDX_W-1:0] fl_idx;

  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign req_loc = req_addr[LOC_W-1:0];
  assign req_idx = req_addr[OFF_W +: IDX_W];
  assign {fl_tag, fl_idx} = fill_addr;

  logic             tag_hit;
  logic             buf_v;
  logic [LOC_W-1:0] buf_loc;
  logic [DW-1:0]    buf_data;
  logic             buf_match;
  logic [DW-1:0]    arr_word;

  // Request classification for this cycle.
  logic wr_hit, byp_rd, stall_drain, acc, fill_go, commit, arr_rd, arr_wr;
  arr_op_e arr_op;
  logic [LOC_W-1:0] w_loc;

  assign wr_hit      = req_write && tag_hit;
  assign byp_rd      = !req_write && tag_hit && buf_match;
  assign stall_drain = buf_v && req_valid && !wr_hit && !byp_rd;
  assign req_ready   = !fill_valid && !stall_drain;
  assign acc         = req_valid && req_ready;

  assign fill_ready  = !buf_v;
  assign fill_go     = fill_valid && !buf_v;
  assign commit      = buf_v && (fill_valid || stall_drain || (acc && wr_hit));

  always_comb begin
    if (fill_go)     arr_op = ARR_FILL;
    else if (commit) arr_op = ARR_COMMIT;
    else             arr_op = ARR_IDLE;
  end

  assign w_loc  = fill_go ? {fl_idx, {OFF_W{1'b0}}} : buf_loc;
  assign arr_rd = acc && !req_write && tag_hit && !byp_rd;
  assign arr_wr = (arr_op != ARR_IDLE);

  assign rsp_valid  = acc && !req_write && tag_hit;
  assign rsp_rdata  = byp_rd ? buf_data : arr_word;
  assign miss_valid = acc && !tag_hit;
  assign miss_write = req_write;
  assign miss_addr  = req_addr;

  cwp_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_idx (req_idx),
    .lk_tag (req_tag),
    .lk_hit (tag_hit),
    .fl_en  (fill_go),
    .fl_idx (fl_idx),
    .fl_tag (fl_tag)
  );

  cwp_delay_buf #(.KEY_W(TAG_W), .LOC_W(LOC_W), .DW(DW)) u_dbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc && wr_hit),
    .clear     (commit),
    .ld_key    (req_tag),
    .ld_loc    (req_loc),
    .ld_data   (req_wdata),
    .pr_key    (req_tag),
    .pr_loc    (req_loc),
    .held      (buf_v),
    .held_loc  (buf_loc),
    .held_data (buf_data),
    .pr_match  (buf_match)
  );

  cwp_data_store #(.DW(DW), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (arr_op),
    .w_loc     (w_loc),
    .w_word    (buf_data),
    .fill_line (fill_data),
    .r_loc     (req_loc),
    .r_word    (arr_word)
  );

endmodule

// File: rtl/cwp_write_path_chk.sv
module cwp_write_path_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              miss_valid,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic              buf_v,
  input logic              byp_rd,
  input logic              tag_hit,
  input logic              arr_rd,
  input logic              arr_wr
);

  // R2
  wr_hit_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && tag_hit && !fill_valid |-> req_ready);

  // R2
  wr_hit_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && tag_hit |=> buf_v);

  // R3
  bypass_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && byp_rd && !fill_valid |-> req_ready);

  // R4
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !fill_valid |=> !buf_v);

  // R5
  miss_write_unbuffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && req_write |=> !buf_v);

  // R6
  miss_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> !buf_v);

  // R8
  fill_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !req_ready);

  // R8
  fill_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> fill_ready);

  // R8
  single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_rd && arr_wr));

  // R10
  rsp_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_valid && req_ready && !req_write && !miss_valid);

  // R7
  miss_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> req_valid && req_ready && !rsp_valid && req_addr == req_addr);

endmodule

bind cwp_write_path cwp_write_path_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cwp_write_path_test.sv
module cwp_write_path_test;
  localparam int TAG_W = 4, IDX_W = 3, OFF_W = 1, DW = 16;
  localparam int AW = TAG_W + IDX_W + OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic fill_valid = 1'b0;
  logic [TAG_W+IDX_W-1:0] fill_addr = '0;
  logic [2*DW-1:0] fill_data = '0;
  logic req_ready, rsp_valid, miss_valid, miss_write, fill_ready;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] miss_addr;

  always #4 clk = ~clk;

  cwp_write_path #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .miss_valid(miss_valid), .miss_write(miss_write), .miss_addr(miss_addr),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_addr(fill_addr), .fill_data(fill_data)
  );

  // Behavioural reference: architectural cache image plus a pending flag.
  bit            m_ok  [8];
  logic [3:0]    m_tag [8];
  logic [DW-1:0] m_dat [16];
  bit            pend = 0;
  logic [AW-1:0] pend_a = '0;

  int tests = 0, fails = 0;
  string ph = "R1";
  bit done = 0;

  function automatic logic [AW-1:0] mk(int t, int i, int o);
    return AW'((t << 4) | (i << 1) | o);
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", ph, what, act, exp);
    end
  endtask

  task automatic step(output bit acc_o, output bit fil_o);
    int idx, fidx;
    bit hit, rdy, acc, stall, fgo;
    #1;
    idx   = int'(req_addr[3:1]);
    hit   = m_ok[idx] && m_tag[idx] == req_addr[7:4];
    stall = pend && req_valid && !(req_write && hit) && !(!req_write && hit && req_addr == pend_a);
    rdy   = !fill_valid && !stall;
    acc   = req_valid && rdy;
    fgo   = fill_valid && !pend;
    chk("req_ready", 32'(req_ready), 32'(rdy));
    chk("fill_ready", 32'(fill_ready), 32'(!pend));
    chk("rsp_valid", 32'(rsp_valid), 32'(acc && !req_write && hit));
    if (acc && !req_write && hit) chk("rsp_rdata", 32'(rsp_rdata), 32'(m_dat[req_addr[3:0]]));
    chk("miss_valid", 32'(miss_valid), 32'(acc && !hit));
    if (acc && !hit) begin
      chk("miss_write", 32'(miss_write), 32'(req_write));
      chk("miss_addr", 32'(miss_addr), 32'(req_addr));
    end
    @(posedge clk);
    if (fgo) begin
      fidx = int'(fill_addr[2:0]);
      m_ok[fidx]  = 1;
      m_tag[fidx] = fill_addr[6:3];
      m_dat[fidx*2]   = fill_data[DW-1:0];
      m_dat[fidx*2+1] = fill_data[2*DW-1:DW];
    end
    if (pend && (fill_valid || stall || (acc && req_write && hit))) pend = 0;
    if (acc && req_write && hit) begin
      m_dat[req_addr[3:0]] = req_wdata;
      pend = 1;
      pend_a = req_addr;
    end
    @(negedge clk);
    acc_o = acc;
    fil_o = fgo;
  endtask

  task automatic idle(int n);
    bit a, f;
    for (int k = 0; k < n; k++) step(a, f);
  endtask

  // Present a request; return the number of cycles it waited.
  task automatic do_req(bit w, logic [AW-1:0] a, logic [DW-1:0] d, output int waits);
    bit ac, f;
    waits = 0;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    step(ac, f);
    while (!ac) begin waits++; step(ac, f); end
    req_valid = 0;
  endtask

  task automatic do_fill(int t, int i, logic [DW-1:0] w1, logic [DW-1:0] w0, output int waits);
    bit ac, f;
    waits = 0;
    fill_valid = 1; fill_addr = 7'((t << 3) | i); fill_data = {w1, w0};
    step(ac, f);
    while (!f) begin waits++; step(ac, f); end
    fill_valid = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int wt;
    for (int k = 0; k < 8; k++) begin m_ok[k] = 0; m_tag[k] = '0; end
    for (int k = 0; k < 16; k++) m_dat[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    ph = "R1"; idle(1);
    do_req(0, mk(0, 0, 0), 0, wt);
    ph = "R7"; do_req(0, mk(2, 1, 1), 0, wt);

    ph = "R8";
    do_fill(0, 0, 16'h1001, 16'h1000, wt);
    do_fill(0, 1, 16'h1101, 16'h1100, wt);
    do_fill(3, 5, 16'h3501, 16'h3500, wt);
    chk("fill wait empty", 32'(wt), 0);

    ph = "R10";
    do_req(0, mk(0, 0, 0), 0, wt);
    do_req(0, mk(3, 5, 1), 0, wt);
    ph = "R9"; do_req(0, mk(1, 0, 0), 0, wt);
    do_req(0, mk(0, 5, 0), 0, wt);

    ph = "R2";
    do_req(1, mk(0, 0, 0), 16'hAAAA, wt); chk("wait w1", 32'(wt), 0);
    do_req(1, mk(0, 0, 1), 16'hBBBB, wt); chk("wait w2", 32'(wt), 0);
    do_req(1, mk(0, 1, 0), 16'hCCCC, wt); chk("wait w3", 32'(wt), 0);
    ph = "R3"; do_req(0, mk(0, 1, 0), 0, wt); chk("bypass wait", 32'(wt), 0);
    ph = "R4"; do_req(0, mk(0, 0, 1), 0, wt); chk("stall cycles", 32'(wt), 1);
    do_req(0, mk(0, 1, 0), 0, wt); chk("committed read wait", 32'(wt), 0);
    do_req(0, mk(0, 0, 0), 0, wt);

    ph = "R5"; do_req(1, mk(3, 5, 0), 16'hDDDD, wt);
    ph = "R6"; do_req(1, mk(7, 0, 0), 16'hEEEE, wt); chk("drain cycles", 32'(wt), 1);
    ph = "R5"; do_req(0, mk(0, 0, 0), 0, wt);
    do_req(0, mk(7, 0, 0), 0, wt);
    do_req(0, mk(3, 5, 0), 0, wt);

    ph = "R6"; do_req(1, mk(0, 1, 1), 16'hF0F0, wt);
    do_req(0, mk(9, 2, 0), 0, wt); chk("drain cycles rd", 32'(wt), 1);
    do_req(0, mk(0, 1, 1), 0, wt);

    ph = "R8"; do_req(1, mk(0, 0, 1), 16'h6161, wt);
    do_fill(4, 3, 16'h4301, 16'h4300, wt); chk("fill wait pend", 32'(wt), 1);
    do_req(0, mk(4, 3, 1), 0, wt);
    do_req(0, mk(0, 0, 1), 0, wt);

    ph = "R2";
    do_req(1, mk(0, 1, 0), 16'h1234, wt);
    do_req(1, mk(0, 1, 0), 16'h5678, wt); chk("same word wait", 32'(wt), 0);
    do_req(0, mk(0, 1, 0), 0, wt);
    do_req(0, mk(0, 0, 0), 0, wt);
    do_req(0, mk(0, 1, 0), 0, wt);
    idle(2);

    done = 1;
    summary();
    $finish;
  end

endmodule